// File: doc/BRIEF.md
# Uncached Store Sequencer

This block steers memory-mapped stores out of a store queue one at a time. Such a store is not sent when it executes; its queue entry is only flagged as waiting. The sequencer watches the entry at the dequeue slot. Once the reorder buffer reports that this store is the oldest uncommitted instruction, the sequencer issues a single write on an uncached request/response channel. It then waits for the reply and marks the entry's data as present.

The same dequeue flags drive a writeback port toward the completion bus. When the store is written back, the entry is released. The controller then holds in a wait state until the commit pulse for that store arrives. Only after that does it consider the next uncached store.

A store that faulted is already marked data-present and not waiting, so it skips the channel and goes straight to writeback. The entry flags are kept outside this block. The sequencer only returns one-cycle pulses that clear the waiting flag, set the data-present flag and retire the entry.

Top module: `uc_store_seq`

## Requirements
- R1: A synchronous active-high reset puts the controller in its idle state; in the cycle after reset is released `req_valid` is 0, whatever it was before.
- R2: From idle, the controller enters the request state at the next clock edge only when `head_ok`, `deq_alloc` and `deq_pend` are all 1 together. If any one of them is 0, `req_valid` stays 0.
- R3: `req_valid` stays 1 for as long as `req_ready` is 0. `clr_pend` is 1 exactly in a cycle where `req_valid` and `req_ready` are both 1. After that cycle `req_valid` is 0.
- R4: `resp_ready` is always 1. In the response state, `resp_valid` raises `set_dvalid` in the same cycle and moves the controller to wait. A `resp_valid` seen in any other state gives `set_dvalid` = 0.
- R5: In the wait state no request is raised, even when the start condition of R2 holds. A `commit_pulse` returns the controller to idle at the next edge, and from there a new start condition raises `req_valid` one edge later.
- R6: While `req_valid` is 1, `req_cmd` is the write code 2'b01, `req_uncached` is 1, and `req_addr`, `req_data` and `req_mask` equal `deq_paddr`, `deq_data` and `deq_mask`.
- R7: `wb_valid` equals `deq_alloc & deq_dvalid & ~deq_wbdone`. `mark_wb` is 1 when `wb_valid` and `wb_ready` are both 1, and is 0 otherwise. `wb_data` equals `deq_data`.
- R8: An entry with `deq_dvalid` = 1 and `deq_pend` = 0 (a faulted store) never raises `req_valid`, even with `head_ok` = 1, but it is offered on the writeback port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| head_ok | input | 1 | Dequeue store is at the reorder-buffer head |
| commit_pulse | input | 1 | Commit of the uncached store |
| deq_alloc | input | 1 | Dequeue entry allocated |
| deq_pend | input | 1 | Dequeue entry waiting for uncached issue |
| deq_dvalid | input | 1 | Dequeue entry data present |
| deq_wbdone | input | 1 | Dequeue entry already written back |
| deq_paddr | input | AW | Physical address of dequeue entry |
| deq_data | input | DW | Store data of dequeue entry |
| deq_mask | input | DW/8 | Byte mask of dequeue entry |
| req_valid | output | 1 | Uncached request valid |
| req_ready | input | 1 | Uncached request accepted |
| req_cmd | output | 2 | Request command (write = 2'b01) |
| req_addr | output | AW | Request address |
| req_data | output | DW | Request data |
| req_mask | output | DW/8 | Request byte mask |
| req_uncached | output | 1 | Uncached flag |
| resp_valid | input | 1 | Uncached response valid |
| resp_ready | output | 1 | Response ready, always 1 |
| clr_pend | output | 1 | Clear waiting flag of dequeue entry |
| set_dvalid | output | 1 | Set data-present flag of dequeue entry |
| wb_valid | output | 1 | Writeback valid |
| wb_ready | input | 1 | Writeback accepted |
| wb_data | output | DW | Writeback data |
| mark_wb | output | 1 | Mark written back and release entry |

## Verification
The writeback handshake of the uncached store and its commit pulse can land in the same cycle while the controller sits in wait. The bench drives `wb_ready` and `commit_pulse` together in that state. It checks that `mark_wb` fires in that cycle and that a fresh start condition raises `req_valid` exactly one edge after idle is reached. The bench also holds a stray `resp_valid` high into the wait state, which must not produce a second `set_dvalid`.

// File: rtl/uc_seq_pkg.sv
package uc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RESP = 2'd2,
        ST_WAIT = 2'd3
    } uc_state_e;

    typedef struct packed {
        uc_state_e st;
    } uc_regs_t;

    localparam int unsigned CMD_W   = 2;
    localparam logic [1:0]  CMD_WR  = 2'b01;
endpackage

// File: rtl/uc_seq_fsm.sv
module uc_seq_fsm
    import uc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_ok,
    input  logic req_fire,
    input  logic resp_fire,
    input  logic commit_pulse,
    output logic in_req,
    output logic in_resp
);
    uc_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: if (start_ok)     r_d.st = ST_REQ;
            ST_REQ:  if (req_fire)     r_d.st = ST_RESP;
            ST_RESP: if (resp_fire)    r_d.st = ST_WAIT;
            ST_WAIT: if (commit_pulse) r_d.st = ST_IDLE;
            default:                   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q.st <= ST_IDLE;
        else     r_q   <= r_d;
    end

    assign in_req  = (r_q.st == ST_REQ);
    assign in_resp = (r_q.st == ST_RESP);
endmodule

// File: rtl/uc_req_fmt.sv
module uc_req_fmt
    import uc_seq_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 64,
    localparam int unsigned MW = DW / 8
) (
    input  logic             in_req,
    input  logic             req_ready,
    input  logic [AW-1:0]    deq_paddr,
    input  logic [DW-1:0]    deq_data,
    input  logic [MW-1:0]    deq_mask,
    output logic             req_valid,
    output logic             req_fire,
    output logic [CMD_W-1:0] req_cmd,
    output logic [AW-1:0]    req_addr,
    output logic [DW-1:0]    req_data,
    output logic [MW-1:0]    req_mask,
    output logic             req_uncached,
    output logic             clr_pend
);
    assign req_valid    = in_req;
    assign req_fire     = in_req & req_ready;
    assign clr_pend     = req_fire;
    assign req_cmd      = CMD_WR;
    assign req_uncached = 1'b1;
    assign req_addr     = deq_paddr;
    assign req_data     = deq_data;
    assign req_mask     = deq_mask;
endmodule

// File: rtl/uc_wb_gate.sv
module uc_wb_gate #(
    parameter int unsigned DW = 64
) (
    input  logic          deq_alloc,
    input  logic          deq_dvalid,
    input  logic          deq_wbdone,
    input  logic          wb_ready,
    input  logic [DW-1:0] deq_data,
    output logic          wb_valid,
    output logic [DW-1:0] wb_data,
    output logic          mark_wb
);
    assign wb_valid = deq_alloc & deq_dvalid & ~deq_wbdone;
    assign mark_wb  = wb_valid & wb_ready;
    assign wb_data  = deq_data;
endmodule

// File: rtl/uc_store_seq.sv
module uc_store_seq
    import uc_seq_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 64,
    localparam int unsigned MW = DW / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             head_ok,
    input  logic             commit_pulse,
    input  logic             deq_alloc,
    input  logic             deq_pend,
    input  logic             deq_dvalid,
    input  logic             deq_wbdone,
    input  logic [AW-1:0]    deq_paddr,
    input  logic [DW-1:0]    deq_data,
    input  logic [MW-1:0]    deq_mask,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [CMD_W-1:0] req_cmd,
    output logic [AW-1:0]    req_addr,
    output logic [DW-1:0]    req_data,
    output logic [MW-1:0]    req_mask,
    output logic             req_uncached,
    input  logic             resp_valid,
    output logic             resp_ready,
    output logic             clr_pend,
    output logic             set_dvalid,
    output logic             wb_valid,
    input  logic             wb_ready,
    output logic [DW-1:0]    wb_data,
    output logic             mark_wb
);
    logic in_req, in_resp, req_fire, resp_fire, start_ok;

    assign start_ok   = head_ok & deq_alloc & deq_pend;
    assign resp_ready = 1'b1;
    assign resp_fire  = in_resp & resp_valid;
    assign set_dvalid = resp_fire;

    uc_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_ok     (start_ok),
        .req_fire     (req_fire),
        .resp_fire    (resp_fire),
        .commit_pulse (commit_pulse),
        .in_req       (in_req),
        .in_resp      (in_resp)
    );

    uc_req_fmt #(.AW(AW), .DW(DW)) u_fmt (
        .in_req       (in_req),
        .req_ready    (req_ready),
        .deq_paddr    (deq_paddr),
        .deq_data     (deq_data),
        .deq_mask     (deq_mask),
        .req_valid    (req_valid),
        .req_fire     (req_fire),
        .req_cmd      (req_cmd),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .req_mask     (req_mask),
        .req_uncached (req_uncached),
        .clr_pend     (clr_pend)
    );

    uc_wb_gate #(.DW(DW)) u_wb (
        .deq_alloc  (deq_alloc),
        .deq_dvalid (deq_dvalid),
        .deq_wbdone (deq_wbdone),
        .wb_ready   (wb_ready),
        .deq_data   (deq_data),
        .wb_valid   (wb_valid),
        .wb_data    (wb_data),
        .mark_wb    (mark_wb)
    );
endmodule

// File: rtl/uc_store_seq_chk.sv
module uc_store_seq_chk (
    input logic clk,
    input logic rst,
    input logic head_ok,
    input logic deq_alloc,
    input logic deq_pend,
    input logic req_valid,
    input logic req_ready,
    input logic clr_pend,
    input logic set_dvalid
);
    // R2: a request only starts after the full start condition
    p_start_cond_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(head_ok && deq_alloc && deq_pend));

    // R3: an unaccepted request is held
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> req_valid);

    // R3: an accepted request drops next cycle
    p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_valid);

    // R3: clearing the waiting flag only happens during a request
    p_clr_in_req_r3: assert property (@(posedge clk) disable iff (rst)
        clr_pend |-> req_valid);

    // R4: response capture never overlaps a request
    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_valid, set_dvalid}));

    // R5: after a response the next cycle carries no request
    p_no_req_after_resp_r5: assert property (@(posedge clk) disable iff (rst)
        set_dvalid |=> !req_valid);
endmodule

bind uc_store_seq uc_store_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .head_ok    (head_ok),
    .deq_alloc  (deq_alloc),
    .deq_pend   (deq_pend),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .clr_pend   (clr_pend),
    .set_dvalid (set_dvalid)
);

// File: tb/uc_store_seq_tb.sv
module uc_store_seq_tb;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int MW = DW / 8;

    logic clk = 0;
    logic rst;
    logic head_ok, commit_pulse, deq_alloc, deq_pend, deq_dvalid, deq_wbdone;
    logic [AW-1:0] deq_paddr;
    logic [DW-1:0] deq_data;
    logic [MW-1:0] deq_mask;
    logic req_valid, req_ready, req_uncached, resp_valid, resp_ready;
    logic [1:0] req_cmd;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data, wb_data;
    logic [MW-1:0] req_mask;
    logic clr_pend, set_dvalid, wb_valid, wb_ready, mark_wb;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    uc_store_seq #(.AW(AW), .DW(DW)) u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // {alloc, dvalid, wbdone, wb_ready, exp_wb_valid, exp_mark_wb}
    localparam logic [5:0] WB_VEC [8] = '{
        6'b0_1_0_1_0_0, 6'b1_0_0_1_0_0, 6'b1_1_1_1_0_0, 6'b1_1_0_0_1_0,
        6'b1_1_0_1_1_1, 6'b0_0_0_0_0_0, 6'b1_1_1_0_0_0, 6'b0_1_1_1_0_0
    };

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1; head_ok = 0; commit_pulse = 0; deq_alloc = 0; deq_pend = 0;
        deq_dvalid = 0; deq_wbdone = 0; deq_paddr = 32'h8000_1040;
        deq_data = 64'hDEAD_BEEF_0123_4567; deq_mask = 8'h0F;
        req_ready = 0; resp_valid = 0; wb_ready = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        #1 chk("R1 reset req_valid", req_valid, 0);

        // R7 table walk
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {deq_alloc, deq_dvalid, deq_wbdone, wb_ready} = WB_VEC[i][5:2];
            #1;
            chk("R7 wb_valid", wb_valid, WB_VEC[i][1]);
            chk("R7 mark_wb", mark_wb, WB_VEC[i][0]);
            chk("R7 wb_data", wb_data, deq_data);
        end

        // R2 negative: missing head_ok
        @(negedge clk);
        deq_alloc = 1; deq_pend = 1; deq_dvalid = 0; deq_wbdone = 0; wb_ready = 0; head_ok = 0;
        @(negedge clk); #1 chk("R2 no head no req", req_valid, 0);
        head_ok = 1;
        @(negedge clk); #1 chk("R2 start raises req", req_valid, 1);
        chk("R6 cmd", req_cmd, 2'b01);
        chk("R6 uncached", req_uncached, 1);
        chk("R6 addr", req_addr, deq_paddr);
        chk("R6 data", req_data, deq_data);
        chk("R6 mask", req_mask, deq_mask);
        chk("R3 no clr while unaccepted", clr_pend, 0);
        @(negedge clk); #1 chk("R3 req held", req_valid, 1);
        req_ready = 1;
        #1 chk("R3 clr_pend on accept", clr_pend, 1);
        @(negedge clk);
        req_ready = 0; deq_pend = 0;
        #1 chk("R3 req drops", req_valid, 0);
        chk("R4 resp_ready", resp_ready, 1);
        resp_valid = 1;
        #1 chk("R4 set_dvalid in resp", set_dvalid, 1);
        @(negedge clk);
        // now waiting; stray response and start condition again
        deq_dvalid = 1; deq_pend = 1;
        #1 chk("R4 stray resp ignored", set_dvalid, 0);
        resp_valid = 0;
        @(negedge clk); #1 chk("R5 no req in wait", req_valid, 0);
        // writeback and commit in the same cycle
        wb_ready = 1; commit_pulse = 1;
        #1 chk("R7 mark_wb with commit", mark_wb, 1);
        @(negedge clk);
        wb_ready = 0; commit_pulse = 0; deq_dvalid = 0;
        #1 chk("R5 idle after commit", req_valid, 0);
        @(negedge clk); #1 chk("R5 restart after commit", req_valid, 1);
        // R1 reset during request
        rst = 1;
        @(negedge clk); rst = 0;
        #1 chk("R1 reset clears req", req_valid, 0);

        // R8 faulted store
        deq_pend = 0; deq_dvalid = 1; deq_alloc = 1; head_ok = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk("R8 no request", req_valid, 0);
            chk("R8 wb offered", wb_valid, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule